// File: doc/BRIEF.md
# Four-bit accumulator ALU with flag register

This block is the arithmetic and logic unit of a very small accumulator machine. The accumulator value is always the first operand. The second operand is picked from one of three general data registers by a small source-select field. A 4-bit command, the low nibble of the machine's 8-bit instruction word, chooses the operation. Six operations are defined: add, compare, invert, and, or and exclusive-or.

The result is presented combinationally, together with a write-back strobe that tells the surrounding register file to load it into the accumulator. The register file itself lives outside this block. Four flags are held in a register inside the block: overflow, greater-than, less-than and zero. They change only on a clock edge while the execute strobe is high. Each operation updates only the flags that belong to it, and the others keep their value. Compare sets the relation flags without asking for any write-back, so a program can test values without disturbing the accumulator.

Top module: `alu4_acc`

## Requirements
- R1: Command 4'h0 (add) drives `result` with (accumulator + operand) mod 16 and raises `acc_wr_en` while `exec_en` is high.
- R2: On an executed add, flag bit 3 (overflow) is set to 1 exactly when the unsigned sum exceeds 15, and bit 0 (zero) is set when the 4-bit result is 0. Bits 2 and 1 keep their value.
- R3: Command 4'h1 (compare) never raises `acc_wr_en`. When executed, bit 2 (greater-than) is set to accumulator > operand, bit 1 (less-than) to accumulator < operand, and bit 0 to accumulator == operand, all unsigned. Bit 3 keeps its value.
- R4: Command 4'h2 (invert) drives `result` with the bitwise inverse of the accumulator, whatever the operand and source select are.
- R5: Commands 4'h3, 4'h4 and 4'h5 drive `result` with the bitwise AND, OR and XOR of the accumulator and the operand, and raise `acc_wr_en` while `exec_en` is high.
- R6: On an executed invert, AND, OR or XOR, overflow is cleared and zero reflects result == 0. Greater-than and less-than keep their value.
- R7: While `exec_en` is low, `acc_wr_en` stays low and `flags` does not change at the next clock edge.
- R8: A high `rst` at a clock edge clears all four flags, whatever `exec_en` is.
- R9: Commands 4'h6 to 4'hF never raise `acc_wr_en` and leave `flags` unchanged even when executed.
- R10: `src_sel` picks the operand: 0 gives `reg_b`, 1 gives `reg_c`, 2 gives `reg_d`, and 3 gives the constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| exec_en | input | 1 | Execute strobe; enables write-back and the flag update |
| cmd | input | 4 | Operation command (low nibble of the instruction) |
| src_sel | input | 2 | Second-operand select |
| acc_in | input | 4 | Current accumulator value |
| reg_b | input | 4 | Data register B |
| reg_c | input | 4 | Data register C |
| reg_d | input | 4 | Data register D |
| result | output | 4 | Combinational operation result |
| acc_wr_en | output | 1 | Write-back strobe for the accumulator |
| flags | output | 4 | Registered flags {overflow, greater, less, zero} |

## Verification
The bench builds the block with its default parameters: a 4-bit datapath and three operand sources. At this size every command code, accumulator value and operand value can be driven, so all 4096 combinations are visited. The sums that carry out of bit 3, the compare ties and the zero results are all covered, and the source select is rotated so that all four selections appear. The flag model is updated field by field in the bench, which makes the held flags and the unused codes visible as mismatches. Extra passes with the strobe low, and a reset asserted while the strobe is high, cover the hold and clear behaviour.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int unsigned ALU_W = 4;

    typedef enum logic [3:0] {
        OP_ADD = 4'h0,
        OP_CMP = 4'h1,
        OP_INV = 4'h2,
        OP_AND = 4'h3,
        OP_OR  = 4'h4,
        OP_XOR = 4'h5
    } alu_op_e;

    // Bit 3 overflow, bit 2 greater, bit 1 less, bit 0 zero.
    typedef struct packed {
        logic ovf;
        logic gt;
        logic lt;
        logic zero;
    } alu_flags_t;

    typedef struct packed {
        logic       wr;
        alu_flags_t mask;
        alu_flags_t val;
    } alu_ctl_t;

    function automatic logic op_is_logic(input logic [3:0] c);
        return (c == OP_INV) || (c == OP_AND) || (c == OP_OR) || (c == OP_XOR);
    endfunction

    function automatic logic op_is_defined(input logic [3:0] c);
        return c <= 4'h5;
    endfunction

    function automatic alu_flags_t merge_flags(input alu_flags_t cur,
                                               input alu_flags_t mask,
                                               input alu_flags_t val);
        return (cur & ~mask) | (val & mask);
    endfunction

endpackage

// File: rtl/alu4_src_mux.sv
module alu4_src_mux #(
    parameter int unsigned DATA_W  = 4,
    parameter int unsigned NUM_SRC = 3,
    localparam int unsigned SEL_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0][DATA_W-1:0] src_i,
    input  logic [SEL_W-1:0]               sel_i,
    output logic [DATA_W-1:0]              opd_o
);
    logic [NUM_SRC-1:0][DATA_W-1:0] gated;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign gated[g] = (sel_i == SEL_W'(g)) ? src_i[g] : '0;
    end

    always_comb begin
        opd_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            opd_o = opd_o | gated[i];
        end
    end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  logic [3:0]        cmd_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] x_i,
    output logic [DATA_W-1:0] res_o,
    output alu_ctl_t          ctl_o
);
    logic [DATA_W:0] sum;
    assign sum = {1'b0, a_i} + {1'b0, x_i};

    always_comb begin
        res_o = a_i;
        ctl_o = '0;
        case (alu_op_e'(cmd_i))
            OP_ADD: begin
                res_o          = sum[DATA_W-1:0];
                ctl_o.wr       = 1'b1;
                ctl_o.mask     = '{ovf: 1'b1, gt: 1'b0, lt: 1'b0, zero: 1'b1};
                ctl_o.val.ovf  = sum[DATA_W];
                ctl_o.val.zero = (sum[DATA_W-1:0] == '0);
            end
            OP_CMP: begin
                ctl_o.mask     = '{ovf: 1'b0, gt: 1'b1, lt: 1'b1, zero: 1'b1};
                ctl_o.val.gt   = a_i > x_i;
                ctl_o.val.lt   = a_i < x_i;
                ctl_o.val.zero = a_i == x_i;
            end
            OP_INV, OP_AND, OP_OR, OP_XOR: begin
                case (alu_op_e'(cmd_i))
                    OP_INV:  res_o = ~a_i;
                    OP_AND:  res_o = a_i & x_i;
                    OP_OR:   res_o = a_i | x_i;
                    default: res_o = a_i ^ x_i;
                endcase
                ctl_o.wr       = 1'b1;
                ctl_o.mask     = '{ovf: 1'b1, gt: 1'b0, lt: 1'b0, zero: 1'b1};
                ctl_o.val.ovf  = 1'b0;
                ctl_o.val.zero = (res_o == '0);
            end
            default: begin
                res_o = a_i;
                ctl_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/alu4_flag_reg.sv
module alu4_flag_reg
    import alu4_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_i,
    input  alu_flags_t mask_i,
    input  alu_flags_t val_i,
    output alu_flags_t flags_o
);
    alu_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (upd_i) begin
            flags_q <= merge_flags(flags_q, mask_i, val_i);
        end
    end

    assign flags_o = flags_q;

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(flags_o));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (flags_o == '0));

    p_rel_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $countones({flags_o.gt, flags_o.lt}) <= 1);
endmodule

// File: rtl/alu4_acc.sv
module alu4_acc
    import alu4_pkg::*;
#(
    parameter int unsigned DATA_W  = 4,
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned CMD_W   = 4,
    localparam int unsigned SEL_W  = $clog2(NUM_SRC + 1),
    localparam int unsigned FLAG_W = $bits(alu_flags_t)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [DATA_W-1:0] reg_c,
    input  logic [DATA_W-1:0] reg_d,
    output logic [DATA_W-1:0] result,
    output logic              acc_wr_en,
    output logic [FLAG_W-1:0] flags
);
    logic [NUM_SRC-1:0][DATA_W-1:0] srcs;
    logic [DATA_W-1:0]              opd;
    alu_ctl_t                       ctl;
    alu_flags_t                     flags_q;
    logic [3:0]                     cmd4;

    assign srcs = {reg_d, reg_c, reg_b};
    assign cmd4 = 4'(cmd);

    alu4_src_mux #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) src_mux_i (
        .src_i (srcs),
        .sel_i (src_sel),
        .opd_o (opd)
    );

    alu4_core #(.DATA_W(DATA_W)) core_i (
        .cmd_i (cmd4),
        .a_i   (acc_in),
        .x_i   (opd),
        .res_o (result),
        .ctl_o (ctl)
    );

    alu4_flag_reg flag_reg_i (
        .clk     (clk),
        .rst     (rst),
        .upd_i   (exec_en),
        .mask_i  (ctl.mask),
        .val_i   (ctl.val),
        .flags_o (flags_q)
    );

    assign acc_wr_en = exec_en & ctl.wr;
    assign flags     = flags_q;

    p_cmp_no_wb_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd4 == OP_CMP) |-> !acc_wr_en);

    p_inv_result_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd4 == OP_INV) |-> (result == ~acc_in));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_is_logic(cmd4)) |=> !flags[3]);

    p_unused_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !op_is_defined(cmd4) |=> $stable(flags));

    p_unused_no_wb_r9: assert property (@(posedge clk) disable iff (rst)
        !op_is_defined(cmd4) |-> !acc_wr_en);

    p_idle_no_wb_r7: assert property (@(posedge clk) disable iff (rst)
        !exec_en |-> !acc_wr_en);
endmodule

// File: tb/alu4_acc_tb.sv
module alu4_acc_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_en = 1'b0;
    logic [3:0] cmd = 4'h0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] acc_in = 4'h0, reg_b = 4'h0, reg_c = 4'h0, reg_d = 4'h0;
    logic [3:0] result;
    logic       acc_wr_en;
    logic [3:0] flags;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] exp_flags = 4'h0;

    always #2.5 clk = ~clk;

    alu4_acc dut_i (
        .clk(clk), .rst(rst), .exec_en(exec_en), .cmd(cmd), .src_sel(src_sel),
        .acc_in(acc_in), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d),
        .result(result), .acc_wr_en(acc_wr_en), .flags(flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cmd %0h a %0h sel %0d)",
                     req, act, exp, cmd, acc_in, src_sel);
        end
    endtask

    // Drive one vector, check the combinational outputs, then the flags after the edge.
    task automatic run_vec(input int c, input int a, input int x, input int sel, input bit ex);
        int opd, sum, res, wr;
        logic [3:0] nf;
        @(negedge clk);
        cmd = 4'(c); acc_in = 4'(a); src_sel = 2'(sel); exec_en = ex;
        reg_b = (sel == 0) ? 4'(x) : 4'(~x);
        reg_c = (sel == 1) ? 4'(x) : 4'(x + 5);
        reg_d = (sel == 2) ? 4'(x) : 4'(x + 9);
        opd = (sel == 3) ? 0 : x;
        sum = a + opd;
        nf = exp_flags;
        res = -1; wr = 0;
        case (c)
            0: begin res = sum % 16; wr = 1; nf[3] = (sum > 15); nf[0] = (res == 0); end
            1: begin nf[2] = a > opd; nf[1] = a < opd; nf[0] = a == opd; end
            2: begin res = (~a) & 15; wr = 1; end
            3: begin res = a & opd; wr = 1; end
            4: begin res = a | opd; wr = 1; end
            5: begin res = a ^ opd; wr = 1; end
            default: ;
        endcase
        if (c >= 2 && c <= 5) begin nf[3] = 1'b0; nf[0] = (res == 0); end
        #1;
        if (res >= 0) begin
            if (c == 0)      chk("R1 add result", int'(result), res);
            else if (c == 2) chk("R4 invert result", int'(result), res);
            else             chk("R5 logic result", int'(result), res);
        end
        if (!ex)         chk("R7 no write-back when idle", int'(acc_wr_en), 0);
        else if (c == 1) chk("R3 compare write-back", int'(acc_wr_en), 0);
        else if (c > 5)  chk("R9 unused write-back", int'(acc_wr_en), 0);
        else             chk("R1 R5 write-back strobe", int'(acc_wr_en), wr);
        if (ex) exp_flags = nf;
        @(posedge clk); #1;
        if (!ex)         chk("R7 flags held when idle", int'(flags), int'(exp_flags));
        else if (c == 0) chk("R2 add flags", int'(flags), int'(exp_flags));
        else if (c == 1) chk("R3 compare flags", int'(flags), int'(exp_flags));
        else if (c <= 5) chk("R6 logic flags", int'(flags), int'(exp_flags));
        else             chk("R9 unused flags", int'(flags), int'(exp_flags));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 chk("R8 reset state", int'(flags), 0);
        @(negedge clk); rst = 1'b0;
        // Full sweep of command, accumulator and operand; R10 via rotating select.
        for (int c = 0; c < 16; c++)
            for (int a = 0; a < 16; a++)
                for (int x = 0; x < 16; x++)
                    run_vec(c, a, x, (a + x + c) % 4, 1'b1);
        // Source select: each register alone (R10), compare against 0 for select 3.
        for (int s = 0; s < 4; s++) run_vec(0, 3, 7, s, 1'b1);
        run_vec(1, 5, 9, 3, 1'b1);
        chk("R10 select 3 gives zero operand", int'(flags[2]), 1);
        // Idle passes with strobe low must not move flags (R7).
        run_vec(0, 15, 1, 0, 1'b1);
        run_vec(1, 2, 9, 1, 1'b1);
        for (int c = 0; c < 6; c++) run_vec(c, 15 - c, c, c % 3, 1'b0);
        // R8: reset while executing clears flags.
        run_vec(0, 8, 8, 0, 1'b1);
        @(negedge clk); rst = 1'b1; exec_en = 1'b1; cmd = 4'h1; acc_in = 4'h9; src_sel = 2'd0; reg_b = 4'h1;
        @(posedge clk); #1;
        chk("R8 reset overrides execute", int'(flags), 0);
        exp_flags = 4'h0;
        @(negedge clk); rst = 1'b0;
        run_vec(1, 9, 1, 0, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule